// File: doc/BRIEF.md
# Address Register Add Unit

This block keeps the pointer state of a DSP address generation path and updates it with one of three additions per clock. It holds a 32-bit register file of sixteen address registers, eight modulus registers, four offset registers and two stack pointers. A valid strobe with a 2-bit form code, two register indices and a 16-bit immediate field requests an update. The sum is written on the next rising clock edge. No condition flags are produced.

The low eight address registers can each run in linear or modulo mode. A 32-bit mode control word gives each of them a 4-bit field. In modulo mode the result stays inside a power-of-two buffer. The buffer size is held in the register's paired modulus register, and the buffer base is the pointer aligned down to that size. Any result written to a stack pointer has its low three bits cleared. A status input chooses which of the two stack pointers answers to the stack-pointer index. A combinational read port exposes every physical register.

Top module: `agu_add_unit`

## Requirements
- R1: A synchronous reset clears all 30 registers to zero. The physical indices are: address registers 0–15; modulus registers 16–23, where index 16+k pairs with address register k; offset registers 24–27; stack pointer 0 at 28; stack pointer 1 at 29.
- R2: Form code 0 (short) adds `op_imm[4:0]`, zero-extended, to the register named by `op_dst` and writes the sum back to that register. `op_imm[15:5]` has no effect.
- R3: Form code 1 (long) adds `op_imm`, sign-extended from 16 bits, to the `op_src` register and writes the sum to the `op_dst` register. The write happens only if `op_dst` is an address register (index below 16). Otherwise no register changes.
- R4: Form code 2 (register pair) adds the `op_src` register to the `op_dst` register and writes the sum to the `op_dst` register.
- R5: Every value written to a stack pointer has bits [2:0] forced to zero.
- R6: In `op_src` and `op_dst`, any index of 28 or above names the active stack pointer. `sp_sel` = 0 selects physical 28 and `sp_sel` = 1 selects physical 29. The read port `rd_idx` always addresses physical registers.
- R7: When the written register is address register k with k below 8, bits [4k+3:4k] of `mod_ctrl` set its mode. Code 0 is a linear add. Code 1 is modulo: with size M taken from register 16+k, the result is `(ptr & ~(M-1)) | ((ptr+addend) & (M-1))`, where ptr is the pointer operand (`op_src` for the long form, otherwise `op_dst`). If M is zero, the result is the linear sum.
- R8: Mode codes 2–15 give a linear add. Registers other than address registers 0–7 ignore `mod_ctrl` entirely.
- R9: Form code 3, or `op_valid` low, leaves every register unchanged.
- R10: `rd_data` reflects `rd_idx` combinationally. A write appears on it after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Update request strobe |
| op_form | input | 2 | Add form: 0 short, 1 long, 2 register pair, 3 none |
| op_src | input | 5 | Source register index |
| op_dst | input | 5 | Destination register index |
| op_imm | input | 16 | Immediate field |
| sp_sel | input | 1 | Active stack pointer select |
| mod_ctrl | input | 32 | Per-register mode fields for address registers 0–7 |
| rd_idx | input | 5 | Read port physical index |
| rd_data | output | 32 | Read port data |

## Verification
The bench builds the unit with its default parameters: 32-bit data, sixteen address registers, eight modulus registers, four offset registers, three alignment bits and modulo support enabled. These values place the stack pointers at indices 28 and 29, so the 5-bit index can reach both the active-pointer alias and the two physical slots. A 16-entry modulus is small enough that short immediates and negative long immediates both cross the buffer edge within a few operations. Register 8 sits above the modal range, which shows that the control word is ignored there.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      FORM_SHORT  = 2'd0,
      FORM_LONG   = 2'd1,
      FORM_REGREG = 2'd2,
      FORM_NONE   = 2'd3
   } agu_form_e;

   localparam logic [3:0] MODE_LINEAR = 4'd0;
   localparam logic [3:0] MODE_MODULO = 4'd1;

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 30,
   parameter int IDX_W    = 5
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]    file_q
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            mem[e] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(e)))
            mem[e] <= wr_data;
      end
      assign file_q[e] = mem[e];
   end

endmodule

// File: rtl/agu_modifier.sv
module agu_modifier
   import agu_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int MODE_W        = 4,
   parameter int SP_ALIGN_BITS = 3,
   parameter bit MODULO_EN     = 1'b1
) (
   input  logic [DATA_W-1:0] ptr,
   input  logic [DATA_W-1:0] addend,
   input  logic [MODE_W-1:0] mode,
   input  logic [DATA_W-1:0] modulus,
   input  logic              modal,
   input  logic              to_sp,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] shaped;

   assign sum = ptr + addend;

   if (MODULO_EN) begin : g_modulo
      logic [DATA_W-1:0] mask;
      logic              use_mod;
      assign mask    = modulus - DATA_W'(1);
      assign use_mod = modal && (mode == MODE_W'(MODE_MODULO));
      assign shaped  = use_mod ? ((ptr & ~mask) | (sum & mask)) : sum;
   end else begin : g_linear
      assign shaped = sum;
   end

   if (SP_ALIGN_BITS > 0) begin : g_align
      assign result = to_sp ? {shaped[DATA_W-1:SP_ALIGN_BITS], {SP_ALIGN_BITS{1'b0}}}
                            : shaped;
   end else begin : g_noalign
      assign result = shaped;
   end

endmodule

// File: rtl/agu_add_unit.sv
module agu_add_unit
   import agu_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int NUM_ADDR      = 16,
   parameter int NUM_MODREG    = 8,
   parameter int NUM_OFS       = 4,
   parameter int IDX_W         = 5,
   parameter int SHORT_W       = 5,
   parameter int IMM_W         = 16,
   parameter int MODE_W        = 4,
   parameter int SP_ALIGN_BITS = 3,
   parameter bit MODULO_EN     = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         op_valid,
   input  logic [1:0]                   op_form,
   input  logic [IDX_W-1:0]             op_src,
   input  logic [IDX_W-1:0]             op_dst,
   input  logic [IMM_W-1:0]             op_imm,
   input  logic                         sp_sel,
   input  logic [NUM_MODREG*MODE_W-1:0] mod_ctrl,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [DATA_W-1:0]            rd_data
);

   localparam int MOD_BASE = NUM_ADDR;
   localparam int OFS_BASE = MOD_BASE + NUM_MODREG;
   localparam int SP_BASE  = OFS_BASE + NUM_OFS;
   localparam int NUM_REGS = SP_BASE + 2;
   localparam int MSEL_W   = (NUM_MODREG > 1) ? $clog2(NUM_MODREG) : 1;

   if (NUM_REGS > (1 << IDX_W)) begin : g_chk_idx
      $error("register file does not fit the index width");
   end
   if (NUM_MODREG > NUM_ADDR) begin : g_chk_mod
      $error("more modal registers than address registers");
   end
   if (SHORT_W > IMM_W || IMM_W > DATA_W) begin : g_chk_imm
      $error("immediate widths inconsistent with data width");
   end
   if (SP_ALIGN_BITS >= DATA_W) begin : g_chk_align
      $error("alignment exceeds data width");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] file_q;
   logic [IDX_W-1:0]  src_phys, dst_phys, wr_idx;
   logic [DATA_W-1:0] src_val, dst_val, ptr, addend, modulus, wr_data;
   logic              wr_en, modal, to_sp;
   logic [MSEL_W-1:0] mode_sel;
   logic [MODE_W-1:0] mode;
   logic [MODE_W-1:0] mode_f [NUM_MODREG];

   // Stack-pointer alias: any index at or above SP_BASE names the active one
   assign src_phys = (op_src >= IDX_W'(SP_BASE)) ? IDX_W'(SP_BASE) + IDX_W'(sp_sel) : op_src;
   assign dst_phys = (op_dst >= IDX_W'(SP_BASE)) ? IDX_W'(SP_BASE) + IDX_W'(sp_sel) : op_dst;

   assign src_val = file_q[src_phys];
   assign dst_val = file_q[dst_phys];
   assign rd_data = (rd_idx < IDX_W'(NUM_REGS)) ? file_q[rd_idx] : '0;

   always_comb begin
      wr_idx = dst_phys;
      wr_en  = 1'b0;
      ptr    = dst_val;
      addend = '0;
      unique case (agu_form_e'(op_form))
         FORM_SHORT: begin
            addend = {{(DATA_W-SHORT_W){1'b0}}, op_imm[SHORT_W-1:0]};
            wr_en  = op_valid;
         end
         FORM_LONG: begin
            ptr    = src_val;
            addend = {{(DATA_W-IMM_W){op_imm[IMM_W-1]}}, op_imm};
            wr_en  = op_valid && (op_dst < IDX_W'(NUM_ADDR));
         end
         FORM_REGREG: begin
            addend = src_val;
            wr_en  = op_valid;
         end
         default: wr_en = 1'b0;
      endcase
   end

   for (genvar k = 0; k < NUM_MODREG; k++) begin : g_mode
      assign mode_f[k] = mod_ctrl[k*MODE_W +: MODE_W];
   end

   assign mode_sel = wr_idx[MSEL_W-1:0];
   assign modal    = wr_idx < IDX_W'(NUM_MODREG);
   assign mode     = mode_f[mode_sel];
   assign modulus  = file_q[IDX_W'(MOD_BASE) + IDX_W'(mode_sel)];
   assign to_sp    = wr_idx >= IDX_W'(SP_BASE);

   agu_modifier #(
      .DATA_W(DATA_W), .MODE_W(MODE_W),
      .SP_ALIGN_BITS(SP_ALIGN_BITS), .MODULO_EN(MODULO_EN)
   ) u_mod (
      .ptr(ptr), .addend(addend), .mode(mode), .modulus(modulus),
      .modal(modal), .to_sp(to_sp), .result(wr_data)
   );

   agu_regfile #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
   ) u_rf (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .file_q(file_q)
   );

endmodule

// File: rtl/agu_add_unit_chk.sv
module agu_add_unit_chk
   import agu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_ADDR = 16,
   parameter int NUM_REGS = 30,
   parameter int SP_BASE  = 28,
   parameter int IDX_W    = 5,
   parameter int SP_ALIGN_BITS = 3
) (
   input logic                            clk,
   input logic                            rst,
   input logic                            op_valid,
   input logic [1:0]                      op_form,
   input logic                            wr_en,
   input logic [IDX_W-1:0]                wr_idx,
   input logic [DATA_W-1:0]               wr_data,
   input logic [NUM_REGS-1:0][DATA_W-1:0] file_q
);

   AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (file_q[SP_BASE][SP_ALIGN_BITS-1:0] == '0) && (file_q[SP_BASE+1][SP_ALIGN_BITS-1:0] == '0)); // R5

   AST_LONG_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst)
      (wr_en && op_form == 2'(FORM_LONG)) |-> (wr_idx < IDX_W'(NUM_ADDR))); // R3

   AST_NONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_form == 2'(FORM_NONE)) |-> !wr_en); // R9

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(file_q)); // R9

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (file_q[$past(wr_idx)] == $past(wr_data))); // R10

endmodule

bind agu_add_unit agu_add_unit_chk #(
   .DATA_W(DATA_W), .NUM_ADDR(NUM_ADDR), .NUM_REGS(NUM_REGS),
   .SP_BASE(SP_BASE), .IDX_W(IDX_W), .SP_ALIGN_BITS(SP_ALIGN_BITS)
) u_chk (
   .clk(clk), .rst(rst), .op_valid(op_valid), .op_form(op_form),
   .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .file_q(file_q)
);

// File: tb/agu_add_unit_test.sv
`timescale 1ns/1ps
module agu_add_unit_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid;
   logic [1:0]  op_form;
   logic [4:0]  op_src, op_dst, rd_idx;
   logic [15:0] op_imm;
   logic        sp_sel;
   logic [31:0] mod_ctrl;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   agu_add_unit uut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_form(op_form),
      .op_src(op_src), .op_dst(op_dst), .op_imm(op_imm), .sp_sel(sp_sel),
      .mod_ctrl(mod_ctrl), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   typedef struct packed {
      logic        v;
      logic [1:0]  form;
      logic [4:0]  src;
      logic [4:0]  dst;
      logic [15:0] imm;
      logic        sp;
      logic [31:0] mctl;
      logic [4:0]  rd;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd0, 5'd0,  5'd16, 16'h0010, 1'b0, 32'h0,        5'd16, 32'h010, 4'd2},  // R2 load M0
      '{1'b1, 2'd1, 5'd0,  5'd0,  16'h0100, 1'b0, 32'h0,        5'd0,  32'h100, 4'd3},  // R3
      '{1'b1, 2'd1, 5'd0,  5'd1,  16'hFFF0, 1'b0, 32'h0,        5'd1,  32'h0F0, 4'd3},  // R3 sign ext
      '{1'b1, 2'd0, 5'd0,  5'd0,  16'h001C, 1'b0, 32'h1,        5'd0,  32'h10C, 4'd7},  // R7
      '{1'b1, 2'd0, 5'd0,  5'd0,  16'h0007, 1'b0, 32'h1,        5'd0,  32'h103, 4'd7},  // R7 wrap up
      '{1'b1, 2'd0, 5'd0,  5'd0,  16'hFFE5, 1'b0, 32'h0,        5'd0,  32'h108, 4'd2},  // R2 upper ignored
      '{1'b1, 2'd1, 5'd0,  5'd0,  16'hFFF4, 1'b0, 32'h1,        5'd0,  32'h10C, 4'd7},  // R7 wrap down
      '{1'b1, 2'd0, 5'd0,  5'd0,  16'h0007, 1'b0, 32'h2,        5'd0,  32'h113, 4'd8},  // R8 code 2
      '{1'b1, 2'd0, 5'd0,  5'd1,  16'h0004, 1'b0, 32'h10,       5'd1,  32'h0F4, 4'd7},  // R7 M1 zero
      '{1'b1, 2'd0, 5'd0,  5'd8,  16'h0003, 1'b0, 32'hFFFFFFFF, 5'd8,  32'h003, 4'd8},  // R8 R8 not modal
      '{1'b1, 2'd0, 5'd0,  5'd28, 16'h001F, 1'b0, 32'h0,        5'd28, 32'h018, 4'd5},  // R5
      '{1'b1, 2'd0, 5'd0,  5'd28, 16'h0011, 1'b1, 32'h0,        5'd29, 32'h010, 4'd6},  // R6
      '{1'b1, 2'd3, 5'd0,  5'd28, 16'h0005, 1'b0, 32'h0,        5'd28, 32'h018, 4'd9},  // R9 form 3
      '{1'b1, 2'd2, 5'd1,  5'd28, 16'h0000, 1'b1, 32'h0,        5'd29, 32'h100, 4'd4},  // R4 with R5
      '{1'b1, 2'd2, 5'd8,  5'd24, 16'h0000, 1'b0, 32'h0,        5'd24, 32'h003, 4'd4},  // R4
      '{1'b1, 2'd2, 5'd1,  5'd0,  16'h0000, 1'b0, 32'h1,        5'd0,  32'h117, 4'd7},  // R7 reg pair
      '{1'b1, 2'd1, 5'd0,  5'd20, 16'h0005, 1'b0, 32'h0,        5'd20, 32'h000, 4'd3},  // R3 no write
      '{1'b1, 2'd1, 5'd28, 5'd2,  16'h0008, 1'b0, 32'h0,        5'd2,  32'h020, 4'd6},  // R6 source alias
      '{1'b0, 2'd0, 5'd0,  5'd2,  16'h0001, 1'b0, 32'h0,        5'd2,  32'h020, 4'd9},  // R9 idle
      '{1'b1, 2'd0, 5'd0,  5'd29, 16'h0008, 1'b0, 32'h0,        5'd28, 32'h020, 4'd6}   // R6 index 29 alias
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      op_valid = 1'b0; op_form = 2'd3; op_src = '0; op_dst = '0;
      op_imm = '0; sp_sel = 1'b0; mod_ctrl = '0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      idle();
      rd_idx = '0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      for (int i = 0; i < 30; i += 7) begin
         rd_idx = 5'(i); #1;
         check(1, rd_data, 32'h0);
      end
      rd_idx = 5'd29; #1;
      check(1, rd_data, 32'h0);

      for (int n = 0; n < NV; n++) begin
         @(negedge clk);
         op_valid = VECS[n].v;   op_form = VECS[n].form;
         op_src   = VECS[n].src; op_dst  = VECS[n].dst;
         op_imm   = VECS[n].imm; sp_sel  = VECS[n].sp;
         mod_ctrl = VECS[n].mctl;
         @(negedge clk);
         idle();
         rd_idx = VECS[n].rd; #1;
         check(int'(VECS[n].req), rd_data, VECS[n].exp);
      end

      // R10: value not visible before the edge, visible after
      @(negedge clk);
      rd_idx = 5'd3;
      op_valid = 1'b1; op_form = 2'd0; op_dst = 5'd3; op_imm = 16'h0009;
      #1;
      check(10, rd_data, 32'h0);
      @(negedge clk);
      idle(); #1;
      check(10, rd_data, 32'h9);

      // R1: reset in mid-run clears loaded registers
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd_idx = 5'd0;  #1; check(1, rd_data, 32'h0);
      rd_idx = 5'd16; #1; check(1, rd_data, 32'h0);
      rd_idx = 5'd29; #1; check(1, rd_data, 32'h0);
      rd_idx = 5'd24; #1; check(1, rd_data, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule